// File: doc/BRIEF.md
# Acknowledge-Polling Byte Write Master

This block drives a two-wire serial bus as its only master. It writes one byte into a small serial memory slave, then waits for the slave's internal programming to finish. A user pulses a start request together with a word address and a data byte. The block then sends a START, a control byte carrying the device code and a write direction bit, the word address byte, the data byte and a STOP. That STOP sets off the slave's internal write.

Right after that STOP the block probes the slave. Each probe is a START followed by the same write control byte. While the slave is still programming it does not acknowledge, so the block issues a repeated START and probes again. When a probe is acknowledged, the block closes the bus with a STOP and raises `done`. There are two error cases:
- a missing acknowledge on any byte of the write itself;
- a run of unanswered probes reaching the limit.

In both cases the block releases the bus with a STOP and raises `error`.

The bus clock is open-drain style. `sclOut` high means released. `sdaPullLow` high means the data line is pulled low. The sampled line state comes back on `sdaIn`. Bit timing comes from the system clock: `HALF_DIV` clocks per SCL half period, and data changes `SDA_HOLD` clocks after SCL falls.

Top module: `ack_poll_writer`

## Requirements
- R1: After reset, SCL is released high, SDA is not pulled, and `busy`, `done` and `error` are all low.
- R2: A start request while idle latches the address and data and raises `busy` on the next clock. A start request while `busy` is high is ignored and has no effect on the bytes written.
- R3: The write transaction is START, then the control byte, then the address byte, then the data byte, then STOP. All bytes are sent most significant bit first. The control byte is binary 1010, then the three `SEL_BITS`, then a 0 for the write direction. The address byte is the word address with zeros above it.
- R4: SDA changes while SCL is high only for a START (falling) or a STOP (rising). Every other change of `sdaPullLow` happens exactly `SDA_HOLD` clocks after SCL falls.
- R5: During the ninth clock of each byte the master releases SDA. A low level sampled at the end of that ninth high period counts as an acknowledge.
- R6: After the write STOP, the master probes with START plus the control byte of R3. After an unacknowledged probe it sends a repeated START and the control byte again.
- R7: After an acknowledged probe, the master sends STOP, then sets `done` and drops `busy` in the same clock.
- R8: If `POLL_LIMIT` probes in a row go unacknowledged, the master sends STOP and sets `error` instead of `done`.
- R9: A missing acknowledge on the control, address or data byte of the write stops the transaction at once with STOP and sets `error`, with no probing.
- R10: Every SCL low period lasts exactly `HALF_DIV` clocks, and every SCL high period lasts at least `HALF_DIV` clocks.
- R11: `done` and `error` are never set together. Each stays set until the next accepted start request clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request one write-and-poll operation |
| wordAddr | input | ADDR_W | Memory word address |
| wrData | input | 8 | Byte to write |
| sdaIn | input | 1 | Sampled level of the data line |
| sclOut | output | 1 | Bus clock (1 = released high) |
| sdaPullLow | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Write confirmed by an acknowledged probe |
| error | output | 1 | Write refused or poll limit reached |

## Verification
The bench builds the block with the following parameters:
- `HALF_DIV` = 4 and `SDA_HOLD` = 1, so each byte takes only a few dozen clocks and a one-clock data delay can be told apart from a change on the SCL edge itself.
- `POLL_LIMIT` = 5, so the give-up path is reached after five refused probes.
- `SEL_BITS` = 101, so the three select bits are not all equal and a swapped or dropped select bit shows up in the control byte.

A behavioural slave model can refuse any chosen number of probes or any single write byte. This reaches the success, timeout and early-abort paths.

// File: rtl/apw_pkg.sv
package apw_pkg;

  typedef enum logic [1:0] {
    SYM_START = 2'd0,
    SYM_STOP  = 2'd1,
    SYM_BYTE  = 2'd2
  } symKind_t;

  // Strobe bundle from control to the bit engine
  typedef struct packed {
    logic     go;
    symKind_t kind;
    logic [7:0] payload;
  } symCmd_t;

endpackage

// File: rtl/apw_bitgen.sv
module apw_bitgen
  import apw_pkg::*;
#(
  parameter int HALF_DIV = 8,
  parameter int SDA_HOLD = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  symCmd_t cmd,
  input  logic    sdaIn,
  output logic    symDone,
  output logic    ackSeen,
  output logic    engBusy,
  output logic    sclOut,
  output logic    sdaPullLow
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] HOLD_AT   = CNT_W'(SDA_HOLD);
  localparam logic [4:0] BYTE_LAST  = 5'd17;
  localparam logic [4:0] COND_LAST  = 5'd2;

  logic             busyQ, sclQ, pullQ, doneQ, ackQ;
  logic [CNT_W-1:0] cnt;
  logic [4:0]       halfIdx;
  symKind_t         kindQ;
  logic [7:0]       shiftQ;

  logic       highHalf, setSda, sdaTarget, sampleAck;
  logic [4:0] lastHalf;
  logic [3:0] bitIdx;

  assign bitIdx   = halfIdx[4:1];
  assign lastHalf = (kindQ == SYM_BYTE) ? BYTE_LAST : COND_LAST;

  always_comb begin
    highHalf  = (kindQ == SYM_BYTE) ? halfIdx[0] : (halfIdx != 5'd0);
    setSda    = 1'b0;
    sdaTarget = 1'b0;
    sampleAck = 1'b0;
    case (kindQ)
      SYM_BYTE: begin
        setSda    = !halfIdx[0] && (cnt == HOLD_AT);
        sdaTarget = bitIdx[3] ? 1'b0 : ~shiftQ[~bitIdx[2:0]];
        sampleAck = (halfIdx == BYTE_LAST) && (cnt == HALF_LAST);
      end
      SYM_START: begin
        if (halfIdx == 5'd0 && cnt == HOLD_AT) begin setSda = 1'b1; sdaTarget = 1'b0; end
        if (halfIdx == 5'd2 && cnt == '0)      begin setSda = 1'b1; sdaTarget = 1'b1; end
      end
      default: begin
        if (halfIdx == 5'd0 && cnt == HOLD_AT) begin setSda = 1'b1; sdaTarget = 1'b1; end
        if (halfIdx == 5'd2 && cnt == '0)      begin setSda = 1'b1; sdaTarget = 1'b0; end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      sclQ    <= 1'b1;
      pullQ   <= 1'b0;
      doneQ   <= 1'b0;
      ackQ    <= 1'b0;
      cnt     <= '0;
      halfIdx <= '0;
      kindQ   <= SYM_STOP;
      shiftQ  <= '0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (cmd.go) begin
          busyQ   <= 1'b1;
          kindQ   <= cmd.kind;
          shiftQ  <= cmd.payload;
          cnt     <= '0;
          halfIdx <= '0;
        end
      end else begin
        if (cnt == '0) sclQ <= highHalf;
        if (setSda)    pullQ <= sdaTarget;
        if (sampleAck) ackQ <= ~sdaIn;
        if (cnt == HALF_LAST) begin
          cnt <= '0;
          if (halfIdx == lastHalf) begin
            busyQ <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            halfIdx <= halfIdx + 5'd1;
          end
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign symDone    = doneQ;
  assign ackSeen    = ackQ;
  assign engBusy    = busyQ;
  assign sclOut     = sclQ;
  assign sdaPullLow = pullQ;

  // Data bits never move while the clock is high inside a byte
  assert_sda_steady_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && kindQ == SYM_BYTE && sclQ && $past(sclQ)) |-> $stable(pullQ));

  // Line released throughout the high half of the ninth clock
  assert_ack_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && kindQ == SYM_BYTE && halfIdx == BYTE_LAST) |-> !pullQ);

  // Control only issues a symbol to an idle engine
  assert_go_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmd.go |-> !busyQ);

endmodule

// File: rtl/apw_ctrl.sv
module apw_ctrl
  import apw_pkg::*;
#(
  parameter int         POLL_LIMIT = 64,
  parameter int         ADDR_W     = 4,
  parameter logic [3:0] DEV_CODE   = 4'b1010,
  parameter logic [2:0] SEL_BITS   = 3'b000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [7:0]        wrData,
  input  logic              symDone,
  input  logic              ackSeen,
  output symCmd_t           cmd,
  output logic              busy,
  output logic              done,
  output logic              error
);

  localparam int PC_W = $clog2(POLL_LIMIT + 1);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(POLL_LIMIT - 1);
  localparam logic [7:0] CTRL_WR = {DEV_CODE, SEL_BITS, 1'b0};

  typedef enum logic [3:0] {
    S_IDLE, S_WSTART, S_WCTRL, S_WADDR, S_WDATA, S_WSTOP,
    S_PSTART, S_PCTRL, S_FSTOP, S_ESTOP
  } ctrlState_t;

  ctrlState_t        state;
  logic              inFlight, doneQ, errQ;
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        dataQ;
  logic [PC_W-1:0]   pollCnt;

  always_comb begin
    cmd.go      = (state != S_IDLE) && !inFlight;
    cmd.kind    = SYM_STOP;
    cmd.payload = CTRL_WR;
    case (state)
      S_WSTART, S_PSTART: cmd.kind = SYM_START;
      S_WCTRL, S_PCTRL:   cmd.kind = SYM_BYTE;
      S_WADDR: begin
        cmd.kind    = SYM_BYTE;
        cmd.payload = {{(8-ADDR_W){1'b0}}, addrQ};
      end
      S_WDATA: begin
        cmd.kind    = SYM_BYTE;
        cmd.payload = dataQ;
      end
      default: cmd.kind = SYM_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      inFlight <= 1'b0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
      addrQ    <= '0;
      dataQ    <= '0;
      pollCnt  <= '0;
    end else if (state == S_IDLE) begin
      if (startReq) begin
        addrQ <= wordAddr;
        dataQ <= wrData;
        doneQ <= 1'b0;
        errQ  <= 1'b0;
        state <= S_WSTART;
      end
    end else if (!inFlight) begin
      inFlight <= 1'b1;
    end else if (symDone) begin
      inFlight <= 1'b0;
      case (state)
        S_WSTART: state <= S_WCTRL;
        S_WCTRL:  state <= ackSeen ? S_WADDR : S_ESTOP;
        S_WADDR:  state <= ackSeen ? S_WDATA : S_ESTOP;
        S_WDATA:  state <= ackSeen ? S_WSTOP : S_ESTOP;
        S_WSTOP: begin
          pollCnt <= '0;
          state   <= S_PSTART;
        end
        S_PSTART: state <= S_PCTRL;
        S_PCTRL: begin
          if (ackSeen) state <= S_FSTOP;
          else if (pollCnt == PC_LAST) state <= S_ESTOP;
          else begin
            pollCnt <= pollCnt + PC_W'(1);
            state   <= S_PSTART;
          end
        end
        S_FSTOP: begin
          doneQ <= 1'b1;
          state <= S_IDLE;
        end
        default: begin
          errQ  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  assign busy  = (state != S_IDLE);
  assign done  = doneQ;
  assign error = errQ;

  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < PC_W'(POLL_LIMIT));

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(doneQ && errQ));

  assert_finish_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (doneQ || errQ));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !inFlight);

endmodule

// File: rtl/ack_poll_writer.sv
module ack_poll_writer
  import apw_pkg::*;
#(
  parameter int         HALF_DIV   = 8,
  parameter int         SDA_HOLD   = 2,
  parameter int         POLL_LIMIT = 64,
  parameter int         ADDR_W     = 4,
  parameter logic [3:0] DEV_CODE   = 4'b1010,
  parameter logic [2:0] SEL_BITS   = 3'b000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic [7:0]        wrData,
  input  logic              sdaIn,
  output logic              sclOut,
  output logic              sdaPullLow,
  output logic              busy,
  output logic              done,
  output logic              error
);

  symCmd_t symCmd;
  logic    symDone, ackSeen, engBusy;

  apw_ctrl #(
    .POLL_LIMIT(POLL_LIMIT),
    .ADDR_W    (ADDR_W),
    .DEV_CODE  (DEV_CODE),
    .SEL_BITS  (SEL_BITS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .wordAddr (wordAddr),
    .wrData   (wrData),
    .symDone  (symDone),
    .ackSeen  (ackSeen),
    .cmd      (symCmd),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  apw_bitgen #(
    .HALF_DIV(HALF_DIV),
    .SDA_HOLD(SDA_HOLD)
  ) i_bitgen (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (symCmd),
    .sdaIn      (sdaIn),
    .symDone    (symDone),
    .ackSeen    (ackSeen),
    .engBusy    (engBusy),
    .sclOut     (sclOut),
    .sdaPullLow (sdaPullLow)
  );

  // Engine is idle whenever control has nothing outstanding
  assert_engine_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !engBusy);

endmodule

// File: tb/test_ack_poll_writer.sv
module test_ack_poll_writer;

  localparam int HD   = 4;
  localparam int HOLD = 1;
  localparam int PL   = 5;
  localparam logic [2:0] SEL = 3'b101;
  localparam logic [7:0] EXP_CTRL = 8'hAA;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rstN, startReq;
  logic [3:0] wordAddr;
  logic [7:0] wrData;
  logic       sclOut, sdaPullLow, busy, done, error;
  logic       slavePull;
  wire        sdaLine = ~(sdaPullLow | slavePull);

  int nChecks = 0;
  int nFails  = 0;

  ack_poll_writer #(
    .HALF_DIV(HD), .SDA_HOLD(HOLD), .POLL_LIMIT(PL), .ADDR_W(4),
    .DEV_CODE(4'b1010), .SEL_BITS(SEL)
  ) i_ack_poll_writer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordAddr(wordAddr),
    .wrData(wrData), .sdaIn(sdaLine), .sclOut(sclOut),
    .sdaPullLow(sdaPullLow), .busy(busy), .done(done), .error(error)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  logic [7:0] mem [16];
  int   cfgBusy, cfgNack;
  logic cfgLoad;
  int   busyLeft, nackAt, bitCnt, byteIdx;
  int   probes, starts, stops, badProbe, commits, contention;
  logic active, afterWrite, gotData, prevScl, prevSda;
  logic [7:0] shreg, capCtrl, capAddr, capData;

  always @(posedge clk) begin
    bit ack;
    if (!rstN || cfgLoad) begin
      if (!rstN) for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      prevScl <= 1'b1; prevSda <= 1'b1; slavePull <= 1'b0;
      active <= 1'b0; afterWrite <= 1'b0; gotData <= 1'b0;
      bitCnt <= 0; byteIdx <= 0; probes <= 0; starts <= 0; stops <= 0;
      badProbe <= 0; commits <= 0; contention <= 0;
      busyLeft <= cfgBusy; nackAt <= cfgNack;
    end else begin
      prevScl <= sclOut;
      prevSda <= sdaLine;
      if (prevScl && sclOut && prevSda && !sdaLine) begin
        starts <= starts + 1; active <= 1'b1; bitCnt <= 0; byteIdx <= 0;
        slavePull <= 1'b0; gotData <= 1'b0;
      end else if (prevScl && sclOut && !prevSda && sdaLine) begin
        stops <= stops + 1;
        if (active && gotData && !afterWrite) begin
          mem[capAddr[3:0]] <= capData;
          commits <= commits + 1;
          afterWrite <= 1'b1;
        end
        active <= 1'b0; slavePull <= 1'b0;
      end else if (active) begin
        if (!prevScl && sclOut && bitCnt < 9) begin
          if (bitCnt < 8) shreg <= {shreg[6:0], sdaLine};
          else if (sdaPullLow) contention <= contention + 1;
          bitCnt <= bitCnt + 1;
        end else if (prevScl && !sclOut) begin
          if (bitCnt == 8) begin
            ack = 1'b1;
            if (byteIdx == 0) begin
              if (shreg[7:4] != 4'hA || shreg[0]) ack = 1'b0;
              if (afterWrite) begin
                probes <= probes + 1;
                if (shreg != EXP_CTRL) badProbe <= badProbe + 1;
                if (busyLeft > 0) begin busyLeft <= busyLeft - 1; ack = 1'b0; end
              end else capCtrl <= shreg;
            end else if (byteIdx == 1) capAddr <= shreg;
            else if (byteIdx == 2) capData <= shreg;
            if (!afterWrite && byteIdx == nackAt) ack = 1'b0;
            if (byteIdx == 2 && ack) gotData <= 1'b1;
            if (ack) slavePull <= 1'b1; else active <= 1'b0;
          end else if (bitCnt == 9) begin
            slavePull <= 1'b0; bitCnt <= 0; byteIdx <= byteIdx + 1;
          end
        end
      end
    end
  end

  // ---------------- timing monitor ----------------
  int   cyc, runLen, fallCyc, lowRuns, holdChecks, tErrs;
  logic mPrevScl, mPrevPull;
  always @(posedge clk) begin
    if (!rstN) begin
      cyc <= 0; runLen <= 1; fallCyc <= 0; lowRuns <= 0; holdChecks <= 0;
      tErrs <= 0; mPrevScl <= 1'b1; mPrevPull <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      mPrevScl <= sclOut;
      mPrevPull <= sdaPullLow;
      if (sclOut != mPrevScl) begin
        if (!mPrevScl) begin
          lowRuns <= lowRuns + 1;
          if (runLen != HD) tErrs <= tErrs + 1;
        end else if (runLen < HD) tErrs <= tErrs + 1;
        runLen <= 1;
        if (!sclOut) fallCyc <= cyc;
      end else runLen <= runLen + 1;
      if (sdaPullLow != mPrevPull && !sclOut && !mPrevScl) begin
        holdChecks <= holdChecks + 1;
        if (cyc - fallCyc != HOLD) tErrs <= tErrs + 1;
      end
    end
  end

  // ---------------- helpers and scenarios ----------------
  task automatic configure(int busyProbes, int nackByte);
    @(negedge clk);
    cfgBusy = busyProbes; cfgNack = nackByte; cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic launch(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    wordAddr = a; wrData = d; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic testReset();
    check("R1 scl idle", sclOut, 1);
    check("R1 sda idle", sdaPullLow, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 error", error, 0);
  endtask

  task automatic testBusyPolls();
    configure(2, 9);
    launch(4'h5, 8'h3C);
    check("R2 busy after start", busy, 1);
    repeat (30) @(negedge clk);
    wordAddr = 4'h9; wrData = 8'hFF; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitIdle();
    check("R7 done", done, 1);
    check("R7 no error", error, 0);
    check("R3 ctrl byte", capCtrl, EXP_CTRL);
    check("R3 addr byte", capAddr, 8'h05);
    check("R3 data byte", capData, 8'h3C);
    check("R3 memory", mem[5], 8'h3C);
    check("R2 ignored start", mem[9], 8'h00);
    check("R2 single write", commits, 1);
    check("R6 probes", probes, 3);
    check("R6 probe byte", badProbe, 0);
    check("R6 starts", starts, 4);
    check("R7 stops", stops, 2);
    check("R5 no contention", contention, 0);
  endtask

  task automatic testImmediate();
    configure(0, 9);
    launch(4'hF, 8'hA5);
    check("R11 done cleared", done, 0);
    waitIdle();
    check("R7 done", done, 1);
    check("R3 memory", mem[15], 8'hA5);
    check("R6 one probe", probes, 1);
    check("R7 starts", starts, 2);
    check("R7 stops", stops, 2);
  endtask

  task automatic testTimeout();
    configure(1000, 9);
    launch(4'h2, 8'h11);
    waitIdle();
    check("R8 error", error, 1);
    check("R8 no done", done, 0);
    check("R8 probes", probes, PL);
    check("R8 starts", starts, PL + 1);
    check("R8 stops", stops, 2);
  endtask

  task automatic testNack(int which, logic [3:0] a, logic [7:0] d);
    configure(0, which);
    launch(a, d);
    check("R11 error cleared", error, 0);
    waitIdle();
    check("R9 error", error, 1);
    check("R9 no done", done, 0);
    check("R9 no probe", probes, 0);
    check("R9 one stop", stops, 1);
    check("R9 no write", commits, 0);
    check("R9 memory untouched", mem[a], 8'h00);
  endtask

  task automatic testTiming();
    check("R10/R4 timing errors", tErrs, 0);
    check("R10 low runs seen", int'(lowRuns > 100), 1);
    check("R4 hold changes seen", int'(holdChecks > 20), 1);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    rstN = 1'b0; startReq = 1'b0; wordAddr = '0; wrData = '0;
    cfgBusy = 0; cfgNack = 9; cfgLoad = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBusyPolls();
    testImmediate();
    testTimeout();
    testNack(2, 4'h3, 8'h77);
    testNack(0, 4'h7, 8'h42);
    testNack(1, 4'h8, 8'h24);
    testTiming();
    finishRun();
  end

endmodule